// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a processor core from a pending exception to the first fetch of its handler. On a request it captures the 8-bit vector number, the current 16-bit status word, the 32-bit program counter, the supervisor stack pointer and the vector table base. It then works through a fixed series of states. It emits a forced copy of the status word in supervisor mode with tracing off. It computes where the handler pointer lives. It stores a four-halfword context frame below the supervisor stack pointer. Finally it reads the two-halfword handler pointer and hands it back as the new program counter.

Every memory transfer uses one 16-bit port with a request/ready handshake, so the block tolerates any number of wait states. The states are ST_IDLE (waiting), ST_SNAP (status force published), ST_VEC (table address registered), ST_PUSH (four frame writes), ST_RD_HI and ST_RD_LO (handler pointer reads) and ST_DONE (completion pulse).

The transitions are as follows:
- ST_IDLE goes to ST_SNAP on a request.
- ST_SNAP goes to ST_VEC, and ST_VEC goes to ST_PUSH, each unconditionally.
- ST_PUSH stays put until the fourth write is acknowledged, then goes to ST_RD_HI.
- ST_RD_HI goes to ST_RD_LO, and ST_RD_LO goes to ST_DONE, each on its acknowledge.
- ST_DONE goes back to ST_IDLE.

Top module: `exc_entry_seq`

## Requirements
- R1: Out of reset, busy_o, mem_req_o, sr_wr_o and done_o are all 0.
- R2: A request is taken only when the block is idle; its inputs are captured on that clock edge. A request raised while busy_o is 1 changes neither the frame nor the handler fetch, and it does not start a further sequence.
- R3: In the cycle after acceptance, sr_wr_o pulses for one cycle. During that pulse sr_new_o equals the captured status word with bit 13 (supervisor) set, bits 15 and 14 (trace) cleared, and all other bits, including the interrupt mask in bits 10:8, unchanged.
- R4: The frame is written as four halfword writes in this order: first the format word at SSP-2, then the PC low half at SSP-4, then the PC high half at SSP-6, and last the status word at SSP-8. SSP here is the captured stack pointer, and the status word written is the value before the force.
- R5: The format word has bits 15:12 = 0000 and bits 11:0 = vector number × 4.
- R6: A transfer completes at a rising edge where mem_req_o and mem_rdy_i are both 1. Until then mem_req_o, mem_we_o, mem_addr_o and mem_wdata_o hold steady.
- R7: After the frame, the block reads halfwords at VBR + 4×vector (the high half) and then at that address + 2 (the low half), with mem_we_o = 0.
- R8: After the low read completes, done_o pulses for exactly one cycle. During the pulse pc_new_o = {high, low} and ssp_new_o = SSP-8. busy_o is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Exception request |
| vec_i | input | 8 | Vector number |
| sr_i | input | 16 | Current status word |
| pc_i | input | 32 | Program counter at the exception |
| ssp_i | input | 32 | Supervisor stack pointer |
| vbr_i | input | 32 | Vector table base |
| busy_o | output | 1 | Sequence in progress |
| sr_wr_o | output | 1 | One-cycle strobe for the forced status word |
| sr_new_o | output | 16 | Forced status word |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Byte address of the halfword |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with mem_rdy_i |
| mem_rdy_i | input | 1 | Transfer acknowledge |
| done_o | output | 1 | One-cycle completion pulse |
| pc_new_o | output | 32 | Handler address |
| ssp_new_o | output | 32 | Stack pointer after the frame |

## Verification
A push index stuck or skipped would show up on the write port as a missing, repeated or misaddressed halfword within the four acknowledged writes. A captured register overwritten mid-sequence would show a frame or table address that disagrees with the values held at acceptance. A wrong state transition would show as a missing or extra sr_wr_o or done_o strobe, or as busy_o staying high. All of these are visible within the single sequence that caused them. Varying the wait states exposes any handshake state that advances without an acknowledge, because the address changes while the request is still pending.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SNAP,
        ST_VEC,
        ST_PUSH,
        ST_RD_HI,
        ST_RD_LO,
        ST_DONE
    } exc_state_e;

    // status word bit positions
    localparam int SR_SUPER_BIT = 13;
    localparam int SR_TRC_HI    = 15;
    localparam int SR_TRC_LO    = 14;

    // frame layout
    localparam int       FRAME_WORDS = 4;
    localparam int       OFS_W       = 12;
    localparam logic [3:0] FMT_CODE  = 4'h0;

endpackage

// File: rtl/exc_sr_force.sv
module exc_sr_force
    import exc_pkg::*;
#(
    parameter int SRW = 16
) (
    input  logic [SRW-1:0] sr_in,
    output logic [SRW-1:0] sr_out
);
    always_comb begin
        sr_out               = sr_in;
        sr_out[SR_SUPER_BIT] = 1'b1;
        sr_out[SR_TRC_HI]    = 1'b0;
        sr_out[SR_TRC_LO]    = 1'b0;
    end
endmodule

// File: rtl/exc_vec_calc.sv
module exc_vec_calc #(
    parameter int AW = 32,
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] base,
    input  logic [VW-1:0] vec,
    output logic [AW-1:0] vaddr
);
    localparam int PAD_W = AW - VW - 2;

    logic [AW-1:0] offset;
    assign offset = {{PAD_W{1'b0}}, vec, 2'b00};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  vaddr <= '0;
        else if (en) vaddr <= base + offset;
    end
endmodule

// File: rtl/exc_frame_mux.sv
module exc_frame_mux
    import exc_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 16,
    parameter int VW  = 8,
    parameter int IXW = 2
) (
    input  logic [IXW-1:0]  idx,
    input  logic [DW-1:0]   sr,
    input  logic [2*DW-1:0] pc,
    input  logic [VW-1:0]   vec,
    input  logic [AW-1:0]   ssp,
    output logic [DW-1:0]   word,
    output logic [AW-1:0]   addr
);
    localparam int FMT_W = DW - OFS_W;
    localparam int OPAD  = OFS_W - VW - 2;
    localparam int BYTES = DW / 8;

    logic [DW-1:0] words [FRAME_WORDS];
    logic [AW-1:0] addrs [FRAME_WORDS];

    // push order: index 0 lands highest
    genvar k;
    generate
        for (k = 0; k < FRAME_WORDS; k++) begin : g_slot
            assign addrs[k] = ssp - AW'(BYTES * (k + 1));
            if (k == 0) begin : g_fmt
                assign words[k] = {FMT_CODE[FMT_W-1:0], {OPAD{1'b0}}, vec, 2'b00};
            end else if (k == 1) begin : g_pclo
                assign words[k] = pc[DW-1:0];
            end else if (k == 2) begin : g_pchi
                assign words[k] = pc[2*DW-1:DW];
            end else begin : g_sr
                assign words[k] = sr;
            end
        end
    endgenerate

    assign word = words[idx];
    assign addr = addrs[idx];
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 16,
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [VW-1:0] vec_i,
    input  logic [DW-1:0] sr_i,
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] ssp_i,
    input  logic [AW-1:0] vbr_i,
    output logic          busy_o,
    output logic          sr_wr_o,
    output logic [DW-1:0] sr_new_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    input  logic          mem_rdy_i,
    output logic          done_o,
    output logic [AW-1:0] pc_new_o,
    output logic [AW-1:0] ssp_new_o
);
    localparam int IXW         = $clog2(FRAME_WORDS);
    localparam int BYTES       = DW / 8;
    localparam int FRAME_BYTES = FRAME_WORDS * BYTES;
    localparam logic [IXW-1:0] LAST_IX = IXW'(FRAME_WORDS - 1);

    exc_state_e     state_q, state_d;
    logic [IXW-1:0] idx_q;
    logic [VW-1:0]  vec_q;
    logic [DW-1:0]  sr_q;
    logic [AW-1:0]  pc_q, ssp_q, vbr_q;
    logic [DW-1:0]  hi_q;
    logic [AW-1:0]  pc_new_q;

    logic           xfer;
    logic [AW-1:0]  vaddr;
    logic [DW-1:0]  push_word;
    logic [AW-1:0]  push_addr;
    logic [DW-1:0]  sr_forced;

    assign xfer = mem_req_o && mem_rdy_i;

    exc_sr_force #(.SRW(DW)) u_force (
        .sr_in  (sr_q),
        .sr_out (sr_forced)
    );

    exc_vec_calc #(.AW(AW), .VW(VW)) u_vec (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state_q == ST_VEC),
        .base  (vbr_q),
        .vec   (vec_q),
        .vaddr (vaddr)
    );

    exc_frame_mux #(.AW(AW), .DW(DW), .VW(VW), .IXW(IXW)) u_frame (
        .idx  (idx_q),
        .sr   (sr_q),
        .pc   (pc_q),
        .vec  (vec_q),
        .ssp  (ssp_q),
        .word (push_word),
        .addr (push_addr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_i) state_d = ST_SNAP;
            ST_SNAP:  state_d = ST_VEC;
            ST_VEC:   state_d = ST_PUSH;
            ST_PUSH:  if (xfer && idx_q == LAST_IX) state_d = ST_RD_HI;
            ST_RD_HI: if (xfer) state_d = ST_RD_LO;
            ST_RD_LO: if (xfer) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            vec_q    <= '0;
            sr_q     <= '0;
            pc_q     <= '0;
            ssp_q    <= '0;
            vbr_q    <= '0;
            hi_q     <= '0;
            pc_new_q <= '0;
        end else begin
            if (state_q == ST_IDLE && req_i) begin
                vec_q <= vec_i;
                sr_q  <= sr_i;
                pc_q  <= pc_i;
                ssp_q <= ssp_i;
                vbr_q <= vbr_i;
                idx_q <= '0;
            end
            if (state_q == ST_PUSH && xfer) idx_q <= idx_q + 1'b1;
            if (state_q == ST_RD_HI && xfer) hi_q <= mem_rdata_i;
            if (state_q == ST_RD_LO && xfer) pc_new_q <= AW'({hi_q, mem_rdata_i});
        end
    end

    // outputs
    always_comb begin
        busy_o      = 1'b1;
        sr_wr_o     = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        done_o      = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy_o = 1'b0;
            ST_SNAP:  sr_wr_o = 1'b1;
            ST_VEC:   ;
            ST_PUSH: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = push_addr;
                mem_wdata_o = push_word;
            end
            ST_RD_HI: begin
                mem_req_o  = 1'b1;
                mem_addr_o = vaddr;
            end
            ST_RD_LO: begin
                mem_req_o  = 1'b1;
                mem_addr_o = vaddr + AW'(BYTES);
            end
            ST_DONE:  done_o = 1'b1;
            default:  busy_o = 1'b0;
        endcase
    end

    assign sr_new_o  = sr_forced;
    assign pc_new_o  = pc_new_q;
    assign ssp_new_o = ssp_q - AW'(FRAME_BYTES);

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int AW = 32,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy_o,
    input logic          sr_wr_o,
    input logic [DW-1:0] sr_new_o,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic [DW-1:0] mem_wdata_o,
    input logic          mem_rdy_i,
    input logic          done_o
);
    // R6
    hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_we_o)
            && $stable(mem_addr_o) && $stable(mem_wdata_o)));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R3
    sr_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_o |-> (sr_new_o[13] && !sr_new_o[15] && !sr_new_o[14]));

    // R3
    sr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_o |=> !sr_wr_o);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_req_o && !done_o && !sr_wr_o));
endmodule

bind exc_entry_seq exc_entry_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .sr_wr_o     (sr_wr_o),
    .sr_new_o    (sr_new_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdy_i   (mem_rdy_i),
    .done_o      (done_o)
);

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [7:0]  vec_i = '0;
    logic [15:0] sr_i = '0;
    logic [31:0] pc_i = '0, ssp_i = '0, vbr_i = '0;
    logic        busy_o, sr_wr_o, mem_req_o, mem_we_o, done_o;
    logic [15:0] sr_new_o, mem_wdata_o;
    logic [15:0] mem_rdata_i = '0;
    logic        mem_rdy_i = 1'b0;
    logic [31:0] mem_addr_o, pc_new_o, ssp_new_o;

    int checks = 0;
    int errors = 0;
    int wait_n = 0;
    int wcnt = 0;

    // transfer log
    logic [31:0] lg_addr [16];
    logic [15:0] lg_data [16];
    logic        lg_we   [16];
    int          lg_n = 0;
    int          sr_pulses = 0;
    logic [15:0] sr_seen = '0;
    int          dones = 0;
    logic [31:0] pc_seen = '0, ssp_seen = '0;

    exc_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .vec_i(vec_i), .sr_i(sr_i),
        .pc_i(pc_i), .ssp_i(ssp_i), .vbr_i(vbr_i), .busy_o(busy_o),
        .sr_wr_o(sr_wr_o), .sr_new_o(sr_new_o), .mem_req_o(mem_req_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i), .mem_rdy_i(mem_rdy_i), .done_o(done_o),
        .pc_new_o(pc_new_o), .ssp_new_o(ssp_new_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] rd_f(input logic [31:0] a);
        return a[31:16] ^ a[15:0] ^ 16'h5A3C;
    endfunction

    // memory model and monitors, all at the falling edge
    always @(negedge clk) begin
        if (sr_wr_o) begin sr_pulses++; sr_seen = sr_new_o; end
        if (done_o) begin dones++; pc_seen = pc_new_o; ssp_seen = ssp_new_o; end
        if (mem_rdy_i) begin
            mem_rdy_i = 1'b0;
            wcnt = 0;
        end else if (mem_req_o) begin
            if (wcnt >= wait_n) begin
                mem_rdy_i = 1'b1;
                mem_rdata_i = mem_we_o ? 16'h0 : rd_f(mem_addr_o);
                if (lg_n < 16) begin
                    lg_addr[lg_n] = mem_addr_o;
                    lg_data[lg_n] = mem_wdata_o;
                    lg_we[lg_n]   = mem_we_o;
                end
                lg_n++;
            end else wcnt++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic start(input logic [7:0] v, input logic [15:0] s,
                         input logic [31:0] p, input logic [31:0] sp,
                         input logic [31:0] vb);
        lg_n = 0; sr_pulses = 0; dones = 0;
        @(negedge clk);
        vec_i = v; sr_i = s; pc_i = p; ssp_i = sp; vbr_i = vb; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        vec_i = ~v; sr_i = ~s; pc_i = ~p; ssp_i = ~sp; vbr_i = ~vb;
    endtask

    task automatic finish_wait();
        for (int i = 0; i < 400 && dones == 0; i++) @(negedge clk);
    endtask

    task automatic verify(input logic [7:0] v, input logic [15:0] s,
                          input logic [31:0] p, input logic [31:0] sp,
                          input logic [31:0] vb, input string name);
        logic [15:0] exp_sr;
        logic [31:0] va;
        exp_sr = (s | 16'h2000) & 16'h3FFF;
        va = vb + {22'd0, v, 2'b00};
        chk(dones == 1, {name, " R8 done count"}, dones, 1);
        chk(sr_pulses == 1, {name, " R3 sr strobe count"}, sr_pulses, 1);
        chk(sr_seen == exp_sr, {name, " R3 forced sr"}, sr_seen, exp_sr);
        chk(lg_n == 6, {name, " R6 transfer count"}, lg_n, 6);
        if (lg_n == 6) begin
            chk(lg_we[0] && lg_addr[0] == sp - 2, {name, " R4 fmt addr"}, lg_addr[0], sp - 2);
            chk(lg_data[0] == {4'h0, 2'b00, v, 2'b00}, {name, " R5 fmt word"},
                lg_data[0], {4'h0, 2'b00, v, 2'b00});
            chk(lg_addr[1] == sp - 4 && lg_data[1] == p[15:0], {name, " R4 pc lo"},
                lg_data[1], p[15:0]);
            chk(lg_addr[2] == sp - 6 && lg_data[2] == p[31:16], {name, " R4 pc hi"},
                lg_data[2], p[31:16]);
            chk(lg_we[3] && lg_addr[3] == sp - 8 && lg_data[3] == s, {name, " R4 sr word"},
                lg_data[3], s);
            chk(!lg_we[4] && lg_addr[4] == va, {name, " R7 read hi addr"}, lg_addr[4], va);
            chk(!lg_we[5] && lg_addr[5] == va + 2, {name, " R7 read lo addr"},
                lg_addr[5], va + 2);
        end
        chk(pc_seen == {rd_f(va), rd_f(va + 2)}, {name, " R8 pc_new"},
            pc_seen, {rd_f(va), rd_f(va + 2)});
        chk(ssp_seen == sp - 8, {name, " R8 ssp_new"}, ssp_seen, sp - 8);
        chk(busy_o == 1'b0, {name, " R8 busy after done"}, busy_o, 0);
    endtask

    task automatic t_reset();
        chk(!busy_o && !mem_req_o && !sr_wr_o && !done_o, "R1 reset outputs",
            {busy_o, mem_req_o, sr_wr_o, done_o}, 0);
    endtask

    task automatic t_basic();
        wait_n = 0;
        start(8'h19, 16'hC705, 32'h0001_2344, 32'h0000_8000, 32'h0);
        finish_wait();
        verify(8'h19, 16'hC705, 32'h0001_2344, 32'h0000_8000, 32'h0, "basic");
    endtask

    task automatic t_waits();
        wait_n = 3;
        start(8'h40, 16'h0700, 32'hDEAD_BEE0, 32'h0010_0000, 32'h0);
        finish_wait();
        verify(8'h40, 16'h0700, 32'hDEAD_BEE0, 32'h0010_0000, 32'h0, "waits");
        wait_n = 0;
    endtask

    task automatic t_bounds();
        start(8'h00, 16'h8000, 32'h0000_0400, 32'h0000_0010, 32'h0);
        finish_wait();
        verify(8'h00, 16'h8000, 32'h0000_0400, 32'h0000_0010, 32'h0, "vec0 R5");
        start(8'hFF, 16'h4FFF, 32'hFFFF_FFFE, 32'h0000_0008, 32'h0);
        finish_wait();
        verify(8'hFF, 16'h4FFF, 32'hFFFF_FFFE, 32'h0000_0008, 32'h0, "vec255 R5");
    endtask

    task automatic t_relocate();
        wait_n = 1;
        start(8'h21, 16'h2300, 32'h0800_1000, 32'h2000_0100, 32'h00F0_0400);
        finish_wait();
        verify(8'h21, 16'h2300, 32'h0800_1000, 32'h2000_0100, 32'h00F0_0400, "reloc R7");
        wait_n = 0;
    endtask

    task automatic t_busy_req();
        wait_n = 2;
        start(8'h05, 16'h0001, 32'h0000_2000, 32'h0000_4000, 32'h0000_1000);
        @(negedge clk); @(negedge clk);
        vec_i = 8'h77; sr_i = 16'hFFFF; pc_i = 32'h1; ssp_i = 32'h9000;
        vbr_i = 32'h5; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        finish_wait();
        verify(8'h05, 16'h0001, 32'h0000_2000, 32'h0000_4000, 32'h0000_1000, "busy R2");
        for (int i = 0; i < 10; i++) @(negedge clk);
        chk(!busy_o && dones == 1 && lg_n == 6, "R2 no second sequence", lg_n, 6);
        wait_n = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_waits();
        t_bounds();
        t_relocate();
        t_busy_req();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule